// File: doc/BRIEF.md
# Cluster Power Controller Register Slave

This block is the register face of a power controller that serves two processor clusters. Software reaches it over a plain 32-bit register bus made of a byte address, a write enable, a read enable, write data and combinational read data. Through it software can request a new performance level for either cluster, or read back a word from a small operating-point table. It can also arm wake-up sources, enable power-down per cluster, park a resume address for each CPU and see which CPUs sit in standby wait-for-interrupt.

Each request runs on one shared timer. The block accepts one request at a time. After a fixed, parameterised number of cycles it posts a completion or an error flag in a per-request-type status field and raises a level interrupt. Reading the status register acknowledges every flag. A request that arrives while another is in flight is dropped, and it still gets an outcome: an error flag for its own type, posted together with the running request's result. Software that waits on a flag can therefore never be left without an answer.

Top module: `clpwr_top`

## Requirements
- R1: After reset, every readable register returns 0 and `irqOut` is low.
- R2: Mailboxes are full 32-bit words at 0x68/0x6C (cluster A CPU 0/1) and 0x78/0x7C (cluster B CPU 0/1). The power-down enables sit at 0x30 (A) and 0x34 (B) and keep bit 0 only. The wake mask at 0x24 keeps bits 0-1 (A CPU n at bit n), 4-5 (B CPU n at bit n+4) and 10-11 (global enables), so all-ones reads 0xC33. Unmapped addresses read 0 and writes to them are dropped.
- R3: A write to a level register (0x00 for cluster A, 0x08 for cluster B) starts a request of type 0 (A) or 1 (B). The register keeps its old index until the request completes. An index below 8 then takes effect and status bit 4t is set, where t is the type.
- R4: A level write with a value of 8 or more completes with error bit 4t+1 set, and the level stays unchanged.
- R5: A write to the command register 0x10 with bit 31 set starts a configuration request (type 2). The function code sits in bits 30:20 and the word offset in bits 19:0. Function 6 at word offsets 0x304-0x30B (cluster A entries 0-7) or 0x30C-0x313 (cluster B entries 0-7) puts the table word in read-data register 0x74 and sets status bit 8.
- R6: Table entry i carries millivolts in bits 31:20 and a frequency code in bits 19:0. Cluster A: 800+25i mV with code 25000+5000i. Cluster B: 850+20i mV with code 17500+2500i.
- R7: Function 14 at word offset 0 loads the standby register into 0x74 and sets bit 8. Any other function or offset sets error bit 9 and leaves 0x74 unchanged.
- R8: A command write with bit 31 clear starts nothing. The command register always reads back the last word written to it.
- R9: A request that arrives while another is in flight is dropped. When the running one finishes, error bit 4t+1 of the dropped request's type is set, and the dropped request changes no level and no read data.
- R10: `irqOut` is high exactly while any status bit (0x18) is set. A read of 0x18 returns the flags and clears them all.
- R11: The standby register (0x3C) samples `wfiIn` every cycle. Cluster A CPU n (`wfiIn[n]`) appears at bit n, and cluster B CPU n (`wfiIn[2+n]`) at bit 3+n.
- R12: The raw wake register (0x28) samples `wakeIn` every cycle. The wake status register (0x2C) reads raw AND mask.
- R13: The outcome of an accepted request is posted on the LATENCY-th rising edge after the one that accepted it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte address, word aligned |
| busWe | input | 1 | Write strobe for one cycle |
| busRd | input | 1 | Read strobe (needed for read-to-clear) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| wakeIn | input | 12 | Wake-up sources, one per mask bit |
| wfiIn | input | 4 | Standby flags, cluster A CPUs low, cluster B high |
| irqOut | output | 1 | Level interrupt, high while any status flag is set |

## Verification
Assertions check several rules on every cycle: the timer never drops an accepted request before its count runs out, the request type stays frozen while it is in flight, a level register or the read-data register moves only on a completion strobe, posted flags land in the status register, and the interrupt falls after an acknowledge that posts nothing. Only the bench's scenarios can show the values themselves. These are the exact cycle on which the outcome appears, the choice between the completion flag and the error flag for edge indices and offsets, the table contents, the combined flags after dropped requests and the bit mapping of the standby and wake registers.

// File: rtl/clpwr_pkg.sv
package clpwr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NCLUS  = 2;
  localparam int NCPU   = 2;
  localparam int NREQ   = 3;
  localparam int STAT_W = 4 * NREQ;
  localparam int LVL_W  = 3;
  localparam int NLVL   = 1 << LVL_W;
  localparam int WAKE_W = 12;
  localparam int STBY_W = 3 + NCPU;
  localparam int NMBOX  = NCLUS * NCPU;
  localparam int MBOX_W = $clog2(NMBOX);
  localparam int ENT_W  = LVL_W + 1;

  localparam logic [ADDR_W-1:0] OFF_LVL_A = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LVL_B = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_WMASK = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_WRAW  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_WSTAT = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PD_A  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_PD_B  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_STBY  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_MB_A  = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_RDAT  = 8'h74;
  localparam logic [ADDR_W-1:0] OFF_MB_B  = 8'h78;

  localparam logic [10:0] FN_TABLE = 11'd6;
  localparam logic [10:0] FN_STBY  = 11'd14;
  localparam logic [19:0] TBL_BASE_W = 20'h304;
  localparam logic [WAKE_W-1:0] MASK_KEEP = 12'hC00
                                          | 12'((1 << NCPU) - 1)
                                          | 12'(((1 << NCPU) - 1) << 4);

  typedef enum logic [1:0] {
    REQ_LVL_A = 2'd0,
    REQ_LVL_B = 2'd1,
    REQ_CFG   = 2'd2
  } reqType_e;

  typedef struct packed {
    logic              wrMask;
    logic              wrPdA;
    logic              wrPdB;
    logic              wrCmd;
    logic              wrMbox;
    logic [MBOX_W-1:0] mboxSel;
    logic              clrStatus;
    logic [STAT_W-1:0] statSet;
    logic              setLvlA;
    logic              setLvlB;
    logic [LVL_W-1:0]  newLvl;
    logic              loadResult;
    logic              resultIsStby;
    logic [ENT_W-1:0]  tblEntry;
  } ctrlStrobe_t;

  function automatic logic [ADDR_W-1:0] mboxOff(input int idx);
    if (idx < NCPU) return OFF_MB_A + ADDR_W'(4 * idx);
    return OFF_MB_B + ADDR_W'(4 * (idx - NCPU));
  endfunction

  function automatic logic sameWord(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:2] == b[ADDR_W-1:2];
  endfunction

  function automatic logic [DATA_W-1:0] opEntry(input logic [ENT_W-1:0] ent);
    logic [11:0] mv;
    logic [19:0] code;
    logic [LVL_W-1:0] i;
    i = ent[LVL_W-1:0];
    if (!ent[LVL_W]) begin
      mv   = 12'd800 + 12'd25 * {9'd0, i};
      code = 20'd25000 + 20'd5000 * {17'd0, i};
    end else begin
      mv   = 12'd850 + 12'd20 * {9'd0, i};
      code = 20'd17500 + 20'd2500 * {17'd0, i};
    end
    return {mv, code};
  endfunction
endpackage

// File: rtl/clpwr_ctrl.sv
module clpwr_ctrl
  import clpwr_pkg::*;
#(
  parameter int LATENCY = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobe_t       strb
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  reqType_e         curType;
  logic             curBad;
  logic [LVL_W-1:0] curLvl;
  logic             curStby;
  logic [ENT_W-1:0] curEntry;
  logic [NREQ-1:0]  rejPend;

  logic [NREQ-1:0]  reqVec;
  logic [NREQ-1:0]  rejNow;
  logic             anyReq;
  logic             accept;
  logic             finish;
  logic             lvlBad;
  logic [10:0]      cfgFunc;
  logic [19:0]      cfgOff;
  logic [19:0]      tblRel;
  logic             tblHit;
  logic             stbyHit;

  assign reqVec[0] = busWe && sameWord(busAddr, OFF_LVL_A);
  assign reqVec[1] = busWe && sameWord(busAddr, OFF_LVL_B);
  assign reqVec[2] = busWe && sameWord(busAddr, OFF_CMD) && busWdata[DATA_W-1];
  assign anyReq    = |reqVec;
  assign accept    = anyReq && !busy;
  assign finish    = busy && (cnt == '0);
  assign rejNow    = rejPend | (busy ? reqVec : '0);

  assign lvlBad  = busWdata >= DATA_W'(NLVL);
  assign cfgFunc = busWdata[30:20];
  assign cfgOff  = busWdata[19:0];
  assign tblRel  = cfgOff - TBL_BASE_W;
  assign tblHit  = (cfgFunc == FN_TABLE) && (cfgOff >= TBL_BASE_W)
                && (cfgOff < TBL_BASE_W + 20'(2 * NLVL));
  assign stbyHit = (cfgFunc == FN_STBY) && (cfgOff == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      curType  <= REQ_LVL_A;
      curBad   <= 1'b0;
      curLvl   <= '0;
      curStby  <= 1'b0;
      curEntry <= '0;
      rejPend  <= '0;
    end else begin
      if (finish) begin
        busy    <= 1'b0;
        rejPend <= '0;
      end else if (busy) begin
        cnt     <= cnt - 1'b1;
        rejPend <= rejNow;
      end else if (accept) begin
        busy     <= 1'b1;
        cnt      <= CNT_LOAD;
        curLvl   <= busWdata[LVL_W-1:0];
        curEntry <= tblRel[ENT_W-1:0];
        curStby  <= stbyHit;
        if (reqVec[2]) begin
          curType <= REQ_CFG;
          curBad  <= !(tblHit || stbyHit);
        end else begin
          curType <= reqVec[1] ? REQ_LVL_B : REQ_LVL_A;
          curBad  <= lvlBad;
        end
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.wrMask    = busWe && sameWord(busAddr, OFF_WMASK);
    strb.wrPdA     = busWe && sameWord(busAddr, OFF_PD_A);
    strb.wrPdB     = busWe && sameWord(busAddr, OFF_PD_B);
    strb.wrCmd     = busWe && sameWord(busAddr, OFF_CMD);
    strb.clrStatus = busRd && sameWord(busAddr, OFF_STAT);
    for (int m = 0; m < NMBOX; m++) begin
      if (busWe && sameWord(busAddr, mboxOff(m))) begin
        strb.wrMbox  = 1'b1;
        strb.mboxSel = MBOX_W'(m);
      end
    end
    for (int t = 0; t < NREQ; t++) begin
      if (finish && int'(curType) == t) begin
        if (curBad) strb.statSet[4*t+1] = 1'b1;
        else        strb.statSet[4*t]   = 1'b1;
      end
      if (finish && rejNow[t]) strb.statSet[4*t+1] = 1'b1;
    end
    strb.newLvl       = curLvl;
    strb.setLvlA      = finish && !curBad && (curType == REQ_LVL_A);
    strb.setLvlB      = finish && !curBad && (curType == REQ_LVL_B);
    strb.loadResult   = finish && !curBad && (curType == REQ_CFG);
    strb.resultIsStby = curStby;
    strb.tblEntry     = curEntry;
  end

  // R13
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> busy);
  // R13
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && cnt == CNT_LOAD));
  // R9
  type_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> $stable(curType));
  // R3
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy);
endmodule

// File: rtl/clpwr_datapath.sv
module clpwr_datapath
  import clpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [WAKE_W-1:0] wakeIn,
  input  logic [2*NCPU-1:0] wfiIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [LVL_W-1:0]  lvlA, lvlB;
  logic [DATA_W-1:0] cmdReg;
  logic [STAT_W-1:0] statusReg;
  logic [WAKE_W-1:0] maskReg, rawReg;
  logic              pdA, pdB;
  logic [STBY_W-1:0] stbyReg, stbyNext;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] mbox [NMBOX];

  always_comb begin
    stbyNext = '0;
    for (int n = 0; n < NCPU; n++) begin
      stbyNext[n]     = wfiIn[n];
      stbyNext[3 + n] = wfiIn[NCPU + n];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlA      <= '0;
      lvlB      <= '0;
      cmdReg    <= '0;
      statusReg <= '0;
      maskReg   <= '0;
      rawReg    <= '0;
      pdA       <= 1'b0;
      pdB       <= 1'b0;
      stbyReg   <= '0;
      resultReg <= '0;
    end else begin
      rawReg    <= wakeIn;
      stbyReg   <= stbyNext;
      statusReg <= (strb.clrStatus ? '0 : statusReg) | strb.statSet;
      if (strb.setLvlA) lvlA <= strb.newLvl;
      if (strb.setLvlB) lvlB <= strb.newLvl;
      if (strb.wrCmd)   cmdReg <= busWdata;
      if (strb.wrMask)  maskReg <= busWdata[WAKE_W-1:0] & MASK_KEEP;
      if (strb.wrPdA)   pdA <= busWdata[0];
      if (strb.wrPdB)   pdB <= busWdata[0];
      if (strb.loadResult)
        resultReg <= strb.resultIsStby ? DATA_W'(stbyReg) : opEntry(strb.tblEntry);
    end
  end

  for (genvar g = 0; g < NMBOX; g++) begin : g_mbox
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mbox[g] <= '0;
      else if (strb.wrMbox && strb.mboxSel == MBOX_W'(g)) mbox[g] <= busWdata;
    end
  end

  assign irqOut = |statusReg;

  always_comb begin
    rdData = '0;
    case (busAddr[ADDR_W-1:2])
      OFF_LVL_A[ADDR_W-1:2]: rdData = DATA_W'(lvlA);
      OFF_LVL_B[ADDR_W-1:2]: rdData = DATA_W'(lvlB);
      OFF_CMD[ADDR_W-1:2]:   rdData = cmdReg;
      OFF_STAT[ADDR_W-1:2]:  rdData = DATA_W'(statusReg);
      OFF_WMASK[ADDR_W-1:2]: rdData = DATA_W'(maskReg);
      OFF_WRAW[ADDR_W-1:2]:  rdData = DATA_W'(rawReg);
      OFF_WSTAT[ADDR_W-1:2]: rdData = DATA_W'(rawReg & maskReg);
      OFF_PD_A[ADDR_W-1:2]:  rdData = DATA_W'(pdA);
      OFF_PD_B[ADDR_W-1:2]:  rdData = DATA_W'(pdB);
      OFF_STBY[ADDR_W-1:2]:  rdData = DATA_W'(stbyReg);
      OFF_RDAT[ADDR_W-1:2]:  rdData = resultReg;
      default:               rdData = '0;
    endcase
    for (int m = 0; m < NMBOX; m++)
      if (sameWord(busAddr, mboxOff(m))) rdData = mbox[m];
  end

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && strb.statSet == '0) |=> !irqOut);
  // R10
  flag_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.statSet) |=> ((statusReg & $past(strb.statSet)) == $past(strb.statSet)));
  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setLvlA && !strb.setLvlB) |=> ($stable(lvlA) && $stable(lvlB)));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadResult |=> $stable(resultReg));
endmodule

// File: rtl/clpwr_top.sv
module clpwr_top
  import clpwr_pkg::*;
#(
  parameter int LATENCY = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [11:0] wakeIn,
  input  logic [3:0]  wfiIn,
  output logic        irqOut
);
  ctrlStrobe_t strb;

  clpwr_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRd    (busRd),
    .busWdata (busWdata),
    .strb     (strb)
  );

  clpwr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .wakeIn   (wakeIn),
    .wfiIn    (wfiIn),
    .rdData   (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/clpwr_top_tb.sv
`timescale 1ns/1ps
module clpwr_top_tb;
  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [11:0] wakeIn = '0;
  logic [3:0]  wfiIn = '0;
  logic        irqOut;

  int chkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  int expLvl[2];
  logic [31:0] expRes;

  always #5 clk = ~clk;

  clpwr_top #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .wakeIn(wakeIn), .wfiIn(wfiIn),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expEntry(input int cl, input int i);
    int mv, code;
    if (cl == 0) begin mv = 800 + 25 * i; code = 25000 + 5000 * i; end
    else         begin mv = 850 + 20 * i; code = 17500 + 2500 * i; end
    return (32'(mv) << 20) | 32'(code);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic timedReq(input string req, input logic [7:0] a, input logic [31:0] d,
                          input logic [31:0] expStat);
    logic [31:0] s;
    wr(a, d);
    repeat (LAT - 1) @(negedge clk);
    chk({req, " R13 irq low before latency"}, 32'(irqOut), 32'd0);
    @(negedge clk);
    chk({req, " R13 irq high at latency"}, 32'(irqOut), 32'd1);
    rd(8'h18, s);
    chk({req, " status flags"}, s, expStat);
    chk({req, " R10 irq low after status read"}, 32'(irqOut), 32'd0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd1234));
    expLvl[0] = 0; expLvl[1] = 0; expRes = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irqOut), 32'd0);
    foreach (s[k]) begin end
    for (int a = 0; a < 8'h80; a += 4) begin
      rd(8'(a), s);
      chk($sformatf("R1 reset reg 0x%02h", a), s, 32'd0);
    end

    // R2 address map
    for (int m = 0; m < 4; m++) begin
      logic [7:0] ad;
      logic [31:0] v;
      ad = (m < 2) ? 8'(8'h68 + 4 * m) : 8'(8'h78 + 4 * (m - 2));
      v = $urandom;
      wr(ad, v);
      rd(ad, s);
      chk("R2 mailbox", s, v);
    end
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, s); chk("R2 pd A", s, 32'd1);
    wr(8'h34, 32'hFFFF_FFFE); rd(8'h34, s); chk("R2 pd B", s, 32'd0);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, s); chk("R2 mask keep", s, 32'h0000_0C33);
    wr(8'h40, 32'hDEAD_BEEF); rd(8'h40, s); chk("R2 unmapped", s, 32'd0);

    // R12 wake raw and status
    wr(8'h24, 32'h0000_0811);
    @(negedge clk); wakeIn = 12'hF0F;
    rd(8'h28, s); chk("R12 raw", s, 32'h0000_0F0F);
    rd(8'h2C, s); chk("R12 status", s, 32'h0000_0801);
    @(negedge clk); wakeIn = 12'h0A2;
    rd(8'h2C, s); chk("R12 status follows", s, 32'h0000_0000);

    // R11 standby mapping
    @(negedge clk); wfiIn = 4'b1010;
    rd(8'h3C, s); chk("R11 standby A1 B1", s, 32'h0000_0012);
    @(negedge clk); wfiIn = 4'b0101;
    rd(8'h3C, s); chk("R11 standby A0 B0", s, 32'h0000_0009);

    // R3 level update only on completion
    wr(8'h00, 32'd5);
    rd(8'h00, s); chk("R3 level held while busy", s, 32'd0);
    repeat (LAT) @(negedge clk);
    rd(8'h18, s); chk("R3 A completion", s, 32'h0000_0001);
    rd(8'h00, s); chk("R3 A level", s, 32'd5);
    expLvl[0] = 5;
    timedReq("R3 B level 7", 8'h08, 32'd7, 32'h0000_0010);
    expLvl[1] = 7;
    rd(8'h08, s); chk("R3 B level", s, 32'd7);

    // R4 out-of-range index
    timedReq("R4 A index 8", 8'h00, 32'd8, 32'h0000_0002);
    rd(8'h00, s); chk("R4 A level kept", s, 32'd5);
    timedReq("R4 B index max", 8'h08, 32'hFFFF_FFFF, 32'h0000_0020);
    rd(8'h08, s); chk("R4 B level kept", s, 32'd7);

    // R5/R6 full table
    for (int e = 0; e < 16; e++) begin
      timedReq("R5 table read", 8'h10, 32'h8060_0000 | 32'(20'h304 + e), 32'h0000_0100);
      rd(8'h74, s);
      chk($sformatf("R6 entry %0d", e), s, expEntry(e / 8, e % 8));
    end
    expRes = expEntry(1, 7);

    // R7 standby function and bad offsets
    timedReq("R7 standby func", 8'h10, 32'h80E0_0000, 32'h0000_0100);
    rd(8'h74, s); chk("R7 standby result", s, 32'h0000_0009);
    expRes = 32'h0000_0009;
    timedReq("R7 offset below", 8'h10, 32'h8060_0303, 32'h0000_0200);
    timedReq("R7 offset above", 8'h10, 32'h8060_0314, 32'h0000_0200);
    timedReq("R7 func 5", 8'h10, 32'h8050_0304, 32'h0000_0200);
    rd(8'h74, s); chk("R7 result kept", s, expRes);

    // R8 command without start bit
    wr(8'h10, 32'h0060_0304);
    repeat (LAT + 3) @(negedge clk);
    chk("R8 no request", 32'(irqOut), 32'd0);
    rd(8'h10, s); chk("R8 cmd readback", s, 32'h0060_0304);
    rd(8'h74, s); chk("R8 result kept", s, expRes);

    // R9 dropped requests while busy
    wr(8'h00, 32'd3);
    wr(8'h08, 32'd2);
    wr(8'h10, 32'h8060_0305);
    repeat (LAT) @(negedge clk);
    rd(8'h18, s); chk("R9 merged flags", s, 32'h0000_0221);
    expLvl[0] = 3;
    rd(8'h00, s); chk("R9 A level", s, 32'd3);
    rd(8'h08, s); chk("R9 B level untouched", s, 32'd7);
    rd(8'h74, s); chk("R9 result untouched", s, expRes);
    wr(8'h00, 32'd1);
    wr(8'h00, 32'd6);
    repeat (LAT) @(negedge clk);
    rd(8'h18, s); chk("R9 same type", s, 32'h0000_0003);
    rd(8'h00, s); chk("R9 first index wins", s, 32'd1);
    expLvl[0] = 1;

    // R3/R4/R5/R7 constrained random
    for (int it = 0; it < 30; it++) begin
      if ($urandom_range(0, 1) == 0) begin
        int cl, idx;
        logic [31:0] es;
        cl = $urandom_range(0, 1);
        idx = $urandom_range(0, 9);
        es = (idx < 8) ? (32'd1 << (4 * cl)) : (32'd2 << (4 * cl));
        timedReq(idx < 8 ? "R3 random level" : "R4 random level",
                 cl ? 8'h08 : 8'h00, 32'(idx), es);
        if (idx < 8) expLvl[cl] = idx;
        rd(cl ? 8'h08 : 8'h00, s);
        chk("R3 random level readback", s, 32'(expLvl[cl]));
      end else begin
        int off, fn;
        bit ok;
        off = $urandom_range(32'h300, 32'h316);
        fn = ($urandom_range(0, 3) == 0) ? 5 : 6;
        ok = (fn == 6) && (off >= 32'h304) && (off <= 32'h313);
        timedReq(ok ? "R5 random cfg" : "R7 random cfg", 8'h10,
                 32'h8000_0000 | (32'(fn) << 20) | 32'(off),
                 ok ? 32'h0000_0100 : 32'h0000_0200);
        if (ok) expRes = expEntry((off - 32'h304) / 8, (off - 32'h304) % 8);
        rd(8'h74, s);
        chk("R6 random result", s, expRes);
      end
    end

    finished = 1;
    finishRun();
  end
endmodule